// File: doc/BRIEF.md
# MDIO Management Frame Monitor

This block is a passive listener for a two-wire Ethernet PHY management bus. It never drives either wire. Both the management clock and the data line are oversampled by a much faster system clock. The block finds each rising edge of the management clock and takes the data line's level at that edge as one bit: a high level is 1 and a low level is 0. The bit stream is then parsed into frames.

For every complete, well-formed frame the block produces one decoded record and a single-cycle valid strobe. The record holds the direction, the PHY address, the register address, the 16-bit data word and a turnaround-error flag. Frames with a short preamble, a wrong start pattern or an unknown opcode are dropped, and each of these raises its own one-cycle error pulse. A debug or trace subsystem can use the block to log all management traffic between a MAC and its PHYs.

The management clock may be very slow, and its period may change from bit to bit. No fixed bit time is assumed anywhere in the block.

Top module: `mdio_frame_monitor`

## Requirements
- R1: While reset is held and right after it is released, `rec_valid_o`, `rec_ta_err_o`, `rec_is_read_o`, all three error pulses and all record fields are 0.
- R2: A data bit is taken only at a rising edge of the management clock, after both wires pass through equal synchronizers. The data line must be stable from one system clock before that edge until two system clocks after it. Changes at any other time have no effect. Each clock phase must last at least 4 system clocks.
- R3: A frame is made of at least 32 ones, then the start bits 0 and 1, then a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits. All fields are sent MSB first. Opcode bits 1 then 0 give a read record with `rec_is_read_o` = 1.
- R4: Opcode bits 0 then 1 give a write record with `rec_is_read_o` = 0.
- R5: `rec_valid_o` is high for exactly one system clock. It rises on the 4th system clock edge, counting as the first the edge that first sees the management clock high for the 16th data bit. The record fields hold their value until the next record.
- R6: If a 0 arrives after 1 to 31 consecutive ones, `err_preamble_o` pulses and no record is produced.
- R7: If a full preamble is followed by the start bits 0 and 0, `err_start_o` pulses and no record is produced.
- R8: If the opcode bits are 1,1 or 0,0, `err_opcode_o` pulses and no record is produced.
- R9: In a write, `rec_ta_err_o` is 1 unless the turnaround bits are 1 then 0. In a read, it is 1 when the second turnaround bit is 1. In both cases the record is still produced.
- R10: After a record or any framing error, the block needs 32 fresh consecutive ones before it accepts another frame.
- R11: A preamble longer than 32 ones is accepted.
- R12: Frames decode correctly when every clock phase has a different length, from the 4-clock minimum up to long, slow phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the management clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdc_i | input | 1 | Observed management clock wire |
| mdio_i | input | 1 | Observed management data wire |
| rec_valid_o | output | 1 | One-cycle strobe: a new record is on the record outputs |
| rec_is_read_o | output | 1 | Record direction: 1 = read, 0 = write |
| rec_phy_o | output | 5 | PHY address of the record |
| rec_reg_o | output | 5 | Register address of the record |
| rec_data_o | output | 16 | Data word of the record |
| rec_ta_err_o | output | 1 | Turnaround bits of the record were malformed |
| err_preamble_o | output | 1 | One-cycle pulse: preamble ended before 32 ones |
| err_start_o | output | 1 | One-cycle pulse: start pattern was wrong |
| err_opcode_o | output | 1 | One-cycle pulse: opcode was unknown, frame dropped |

## Verification
A record is due 4 system clocks after the management clock rise that carries the last data bit: two synchronizer stages, one bit-strobe register and one output register. The bench counts system clocks from each rise it drives. When the valid strobe arrives, it records the distance from the latest rise and checks that this distance is exactly 4. Record fields and error pulse counts are compared only after an idle gap of several clocks at the end of each frame, when every pipeline stage has drained. The bench also checks that no strobe ever stays high for two clocks in a row.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

  // Frame parser phases
  typedef enum logic [2:0] {
    S_HUNT   = 3'd0,
    S_START  = 3'd1,
    S_OPCODE = 3'd2,
    S_ADDR   = 3'd3,
    S_TURN   = 3'd4,
    S_DATA   = 3'd5
  } dec_state_e;

endpackage

// File: rtl/mdio_reset_sync.sv
module mdio_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_sync_n = rs_q[1];

endmodule

// File: rtl/mdio_sync_bit.sv
module mdio_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   chain_ext;

  assign chain_ext = {chain_q, d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_ext[STAGES-1:0];
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_edge_sampler.sv
module mdio_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_stb_o,
  output logic bit_val_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic mdc_s, mdio_s;
  logic mdc_prev_q;
  logic rise;
  logic stb_d, stb_q;
  logic val_d, val_q;

  assign raw_lines = {mdio_i, mdc_i};

  // Equal-depth synchronizers keep clock and data aligned
  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    mdio_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines[g]),
      .q_o   (sync_lines[g])
    );
  end

  assign mdc_s  = sync_lines[0];
  assign mdio_s = sync_lines[1];
  assign rise   = mdc_s & ~mdc_prev_q;

  always_comb begin
    stb_d = rise;
    val_d = val_q;
    if (rise) val_d = mdio_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_prev_q <= 1'b0;
      stb_q      <= 1'b0;
      val_q      <= 1'b0;
    end else begin
      mdc_prev_q <= mdc_s;
      stb_q      <= stb_d;
      val_q      <= val_d;
    end
  end

  assign bit_stb_o = stb_q;
  assign bit_val_o = val_q;

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/mdio_run_counter.sv
module mdio_run_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic full_o,
  output logic any_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                      cnt_d = '0;
    else if (inc_i && cnt_q != LIMIT_C) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == LIMIT_C);
  assign any_o  = (cnt_q != '0);

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
  import mdio_mon_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              run_full_i,
  input  logic              run_any_i,
  output logic              run_inc_o,
  output logic              run_clr_o,
  output logic              rec_valid_o,
  output logic              rec_is_read_o,
  output logic [ADDR_W-1:0] rec_phy_o,
  output logic [ADDR_W-1:0] rec_reg_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              rec_ta_err_o,
  output logic              err_pre_o,
  output logic              err_start_o,
  output logic              err_op_o
);

  localparam int AW2       = 2 * ADDR_W;
  localparam int FIELD_MAX = (DATA_W > AW2) ? DATA_W : AW2;
  localparam int BC_W      = $clog2(FIELD_MAX);
  localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(AW2 - 1);
  localparam logic [BC_W-1:0] DATA_LAST = BC_W'(DATA_W - 1);

  dec_state_e        state_q, state_d;
  logic [BC_W-1:0]   cnt_q, cnt_d;
  logic              op_first_q, op_first_d;
  logic              is_read_q, is_read_d;
  logic              ta_first_q, ta_first_d;
  logic              ta_err_q, ta_err_d;
  logic [AW2-1:0]    addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_d, e_pre_d, e_start_d, e_op_d;
  logic              valid_q, e_pre_q, e_start_q, e_op_q;
  logic              load_rec;
  logic              rd_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rta_q;

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    op_first_d = op_first_q;
    is_read_d  = is_read_q;
    ta_first_d = ta_first_q;
    ta_err_d   = ta_err_q;
    addr_d     = addr_q;
    data_d     = data_q;
    valid_d    = 1'b0;
    e_pre_d    = 1'b0;
    e_start_d  = 1'b0;
    e_op_d     = 1'b0;
    load_rec   = 1'b0;
    run_inc_o  = 1'b0;
    run_clr_o  = 1'b0;
    if (bit_stb_i) begin
      unique case (state_q)
        S_HUNT: begin
          if (bit_val_i) begin
            run_inc_o = 1'b1;
          end else begin
            run_clr_o = 1'b1;
            if (run_full_i)     state_d = S_START;
            else if (run_any_i) e_pre_d = 1'b1;
          end
        end
        S_START: begin
          if (bit_val_i) begin
            state_d = S_OPCODE;
            cnt_d   = '0;
          end else begin
            state_d   = S_HUNT;
            e_start_d = 1'b1;
          end
        end
        S_OPCODE: begin
          if (cnt_q == '0) begin
            op_first_d = bit_val_i;
            cnt_d      = BC_W'(1);
          end else begin
            cnt_d = '0;
            if (op_first_q != bit_val_i) begin
              is_read_d = op_first_q;
              state_d   = S_ADDR;
            end else begin
              e_op_d  = 1'b1;
              state_d = S_HUNT;
            end
          end
        end
        S_ADDR: begin
          addr_d = {addr_q[AW2-2:0], bit_val_i};
          if (cnt_q == ADDR_LAST) begin
            cnt_d   = '0;
            state_d = S_TURN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_TURN: begin
          if (cnt_q == '0) begin
            ta_first_d = bit_val_i;
            cnt_d      = BC_W'(1);
          end else begin
            ta_err_d = is_read_q ? bit_val_i : !(ta_first_q && !bit_val_i);
            cnt_d    = '0;
            state_d  = S_DATA;
          end
        end
        S_DATA: begin
          data_d = {data_q[DATA_W-2:0], bit_val_i};
          if (cnt_q == DATA_LAST) begin
            valid_d  = 1'b1;
            load_rec = 1'b1;
            cnt_d    = '0;
            state_d  = S_HUNT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = S_HUNT;
      endcase
    end
  end

  // Parser registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_HUNT;
      cnt_q      <= '0;
      op_first_q <= 1'b0;
      is_read_q  <= 1'b0;
      ta_first_q <= 1'b0;
      ta_err_q   <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
      e_pre_q    <= 1'b0;
      e_start_q  <= 1'b0;
      e_op_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      op_first_q <= op_first_d;
      is_read_q  <= is_read_d;
      ta_first_q <= ta_first_d;
      ta_err_q   <= ta_err_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      valid_q    <= valid_d;
      e_pre_q    <= e_pre_d;
      e_start_q  <= e_start_d;
      e_op_q     <= e_op_d;
    end
  end

  // Record registers, loaded only on frame completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      rdata_q <= '0;
      rta_q   <= 1'b0;
    end else if (load_rec) begin
      rd_q    <= is_read_q;
      phy_q   <= addr_q[AW2-1:ADDR_W];
      reg_q   <= addr_q[ADDR_W-1:0];
      rdata_q <= data_d;
      rta_q   <= ta_err_q;
    end
  end

  assign rec_valid_o   = valid_q;
  assign rec_is_read_o = rd_q;
  assign rec_phy_o     = phy_q;
  assign rec_reg_o     = reg_q;
  assign rec_data_o    = rdata_q;
  assign rec_ta_err_o  = rta_q;
  assign err_pre_o     = e_pre_q;
  assign err_start_o   = e_start_q;
  assign err_op_o      = e_op_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |=> !rec_valid_o);

  // R5
  valid_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> $past(bit_stb_i));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_valid_o, err_pre_o, err_start_o, err_op_o}));

  // R10
  hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && $past(state_q) == S_HUNT) |-> $past(run_full_i));

endmodule

// File: rtl/mdio_frame_monitor.sv
module mdio_frame_monitor #(
  parameter int SYNC_STAGES  = 2,
  parameter int PREAMBLE_LEN = 32,
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              rec_valid_o,
  output logic              rec_is_read_o,
  output logic [ADDR_W-1:0] rec_phy_o,
  output logic [ADDR_W-1:0] rec_reg_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              rec_ta_err_o,
  output logic              err_preamble_o,
  output logic              err_start_o,
  output logic              err_opcode_o
);

  logic rst_sync_n;
  logic bit_stb, bit_val;
  logic run_inc, run_clr, run_full, run_any;

  mdio_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdio_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mdc_i     (mdc_i),
    .mdio_i    (mdio_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val)
  );

  mdio_run_counter #(.LIMIT(PREAMBLE_LEN)) u_run (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc_i  (run_inc),
    .clr_i  (run_clr),
    .full_o (run_full),
    .any_o  (run_any)
  );

  mdio_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .bit_stb_i     (bit_stb),
    .bit_val_i     (bit_val),
    .run_full_i    (run_full),
    .run_any_i     (run_any),
    .run_inc_o     (run_inc),
    .run_clr_o     (run_clr),
    .rec_valid_o   (rec_valid_o),
    .rec_is_read_o (rec_is_read_o),
    .rec_phy_o     (rec_phy_o),
    .rec_reg_o     (rec_reg_o),
    .rec_data_o    (rec_data_o),
    .rec_ta_err_o  (rec_ta_err_o),
    .err_pre_o     (err_preamble_o),
    .err_start_o   (err_start_o),
    .err_op_o      (err_opcode_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |=> !rec_valid_o && !err_preamble_o && !err_start_o && !err_opcode_o);

endmodule

// File: tb/tb_mdio_frame_monitor.sv
module tb_mdio_frame_monitor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mdc, mdio;
  logic        rec_valid, rec_is_read, rec_ta_err;
  logic [4:0]  rec_phy, rec_reg;
  logic [15:0] rec_data;
  logic        err_pre, err_start, err_op;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rise_cyc = 0;
  int rec_cnt = 0, pre_cnt = 0, start_cnt = 0, op_cnt = 0;
  int last_lat = 0;
  int dbl = 0;
  bit prev_valid = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_monitor dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .mdc_i          (mdc),
    .mdio_i         (mdio),
    .rec_valid_o    (rec_valid),
    .rec_is_read_o  (rec_is_read),
    .rec_phy_o      (rec_phy),
    .rec_reg_o      (rec_reg),
    .rec_data_o     (rec_data),
    .rec_ta_err_o   (rec_ta_err),
    .err_preamble_o (err_pre),
    .err_start_o    (err_start),
    .err_opcode_o   (err_op)
  );

  // Observer: samples a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    if (rec_valid) begin
      rec_cnt++;
      last_lat = cyc - rise_cyc;
    end
    if (rec_valid && prev_valid) dbl++;
    prev_valid = rec_valid;
    if (err_pre)   pre_cnt++;
    if (err_start) start_cnt++;
    if (err_op)    op_cnt++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lo);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  // One bit: low phase, rising edge, high phase; junk on MDIO away from the edge
  task automatic send_bit(input bit b, input int lo, input int hi, input bit glitch);
    mdc = 1'b0;
    for (int i = 0; i < lo - 1; i++) begin
      mdio = glitch ? 1'($urandom) : b;
      @(negedge clk);
    end
    mdio = b;
    @(negedge clk);
    mdc = 1'b1;
    rise_cyc = cyc;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < hi - 2; i++) begin
      mdio = glitch ? 1'($urandom) : b;
      @(negedge clk);
    end
  endtask

  function automatic int exp_kind(int pre_len, logic [1:0] st, logic [1:0] op);
    if (pre_len < 32)                    return 1;
    if (st != 2'b01)                     return 2;
    if (op != 2'b10 && op != 2'b01)      return 3;
    return 0;
  endfunction

  function automatic bit exp_ta_err(logic [1:0] op, logic [1:0] ta);
    if (op == 2'b10) return ta[0];
    return ta != 2'b10;
  endfunction

  // half = 0 picks a random phase length 4..12 for every phase
  task automatic send_frame(input string tag, input int pre_len, input logic [1:0] st,
                            input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [1:0] ta, input logic [15:0] data,
                            input int half, input bit glitch);
    bit fq[$];
    int r0, p0, s0, o0, kind, lo, hi;
    r0 = rec_cnt; p0 = pre_cnt; s0 = start_cnt; o0 = op_cnt;
    for (int i = 0; i < pre_len; i++) fq.push_back(1'b1);
    for (int i = 1; i >= 0; i--) fq.push_back(st[i]);
    for (int i = 1; i >= 0; i--) fq.push_back(op[i]);
    for (int i = 4; i >= 0; i--) fq.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) fq.push_back(rg[i]);
    for (int i = 1; i >= 0; i--) fq.push_back(ta[i]);
    for (int i = 15; i >= 0; i--) fq.push_back(data[i]);
    foreach (fq[i]) begin
      lo = (half == 0) ? 4 + int'($urandom % 9) : half;
      hi = (half == 0) ? 4 + int'($urandom % 9) : half;
      send_bit(fq[i], lo, hi, glitch);
    end
    mdc = 1'b0;
    mdio = 1'b1;
    repeat (8) @(negedge clk);
    kind = exp_kind(pre_len, st, op);
    case (kind)
      0: begin
        chk(tag, "record count", rec_cnt - r0, 1);
        chk(tag, "is_read", rec_is_read, op == 2'b10);
        chk(tag, "phy addr", rec_phy, phy);
        chk(tag, "reg addr", rec_reg, rg);
        chk(tag, "data", rec_data, data);
        chk("R9", "ta_err", rec_ta_err, exp_ta_err(op, ta));
        chk("R5", "valid latency", last_lat, 4);
        chk(tag, "no error pulses", (pre_cnt - p0) + (start_cnt - s0) + (op_cnt - o0), 0);
      end
      1: begin
        chk(tag, "no record on short preamble", rec_cnt - r0, 0);
        chk_ge(tag, "preamble error pulses", pre_cnt - p0, 1);
      end
      2: begin
        chk(tag, "no record on bad start", rec_cnt - r0, 0);
        chk(tag, "start error pulses", start_cnt - s0, 1);
      end
      default: begin
        chk(tag, "no record on bad opcode", rec_cnt - r0, 0);
        chk(tag, "opcode error pulses", op_cnt - o0, 1);
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    mdc   = 1'b0;
    mdio  = 1'b1;
    repeat (5) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "valid in reset", rec_valid, 0);
    chk("R1", "errors in reset", {err_pre, err_start, err_op}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "record fields after reset", {rec_is_read, rec_phy, rec_reg, rec_data, rec_ta_err}, 0);
    chk("R1", "no pulses after reset", rec_cnt + pre_cnt + start_cnt + op_cnt, 0);

    // R3 read at the fastest allowed rate, R4 write at a slower one
    send_frame("R3", 32, 2'b01, 2'b10, 5'h15, 5'h0A, 2'b10, 16'hA5C3, 4, 1'b0);
    send_frame("R4", 32, 2'b01, 2'b01, 5'h01, 5'h1F, 2'b10, 16'h0001, 12, 1'b0);
    // R12 very slow and irregular clock
    send_frame("R12", 32, 2'b01, 2'b01, 5'h1E, 5'h03, 2'b10, 16'hFFFE, 40, 1'b0);
    send_frame("R12", 32, 2'b01, 2'b10, 5'h00, 5'h11, 2'b00, 16'h8000, 0, 1'b0);
    // R11 long preamble
    send_frame("R11", 40, 2'b01, 2'b10, 5'h07, 5'h10, 2'b10, 16'h1234, 0, 1'b0);
    // R6 short preamble
    send_frame("R6", 31, 2'b01, 2'b10, 5'h07, 5'h10, 2'b10, 16'h1234, 0, 1'b0);
    // R7 bad start pattern
    send_frame("R7", 32, 2'b00, 2'b01, 5'h03, 5'h04, 2'b10, 16'hBEEF, 0, 1'b0);
    // R8 unknown opcodes
    send_frame("R8", 32, 2'b01, 2'b11, 5'h03, 5'h04, 2'b10, 16'hBEEF, 0, 1'b0);
    send_frame("R8", 32, 2'b01, 2'b00, 5'h03, 5'h04, 2'b10, 16'hBEEF, 0, 1'b0);
    // R10 a frame with no new preamble after an error is not decoded
    send_frame("R10", 0, 2'b01, 2'b01, 5'h09, 5'h09, 2'b10, 16'h5555, 0, 1'b0);
    send_frame("R10", 32, 2'b01, 2'b01, 5'h09, 5'h09, 2'b10, 16'h5555, 0, 1'b0);
    send_frame("R10", 0, 2'b01, 2'b10, 5'h0C, 5'h0D, 2'b10, 16'h00FF, 0, 1'b0);
    // R9 malformed turnarounds still produce records
    send_frame("R9", 32, 2'b01, 2'b01, 5'h02, 5'h02, 2'b11, 16'h0F0F, 0, 1'b0);
    send_frame("R9", 32, 2'b01, 2'b01, 5'h02, 5'h02, 2'b00, 16'hF0F0, 0, 1'b0);
    send_frame("R9", 32, 2'b01, 2'b10, 5'h02, 5'h02, 2'b11, 16'h3C3C, 0, 1'b0);
    // R2 heavy junk on MDIO away from the sampling edge
    send_frame("R2", 32, 2'b01, 2'b10, 5'h1B, 5'h16, 2'b10, 16'hC0DE, 0, 1'b1);

    // Random legal traffic
    for (int n = 0; n < 30; n++) begin
      logic [1:0] op, ta;
      op = ($urandom % 2) ? 2'b10 : 2'b01;
      ta = (op == 2'b10) ? {1'($urandom), 1'b0} : 2'b10;
      send_frame(op == 2'b10 ? "R3" : "R4", 32 + int'($urandom % 4), 2'b01, op,
                 5'($urandom), 5'($urandom), ta, 16'($urandom), 0, 1'($urandom));
    end

    chk("R5", "valid never two cycles long", dbl, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule